// File: doc/BRIEF.md
# PTP Time-of-Day Counter with Fractional Step

This block keeps a running precision-time value made of a nanoseconds field and a 48-bit seconds field. On every clock where it is allowed to run, it adds a programmable fixed-point step to the nanoseconds. When the nanoseconds pass one second, the excess carries into the seconds. The step has 20 fractional bits, and a 20-bit remainder collects the fractional part so that sub-nanosecond rates average out exactly over time.

Software drives the block through a small register port with a valid and a write strobe, and reads data back combinationally. A two-bit command field in the control register asks for a coherent capture of the time or for a reset of the time. The field reads back non-zero while the request is in flight and returns to zero by itself. A new time and a new step are written into staging registers and take effect only when their load bits are set in the control register. Each load bit clears itself once its value has been applied. A source field chooses whether the counter follows the adjustable timebase or stays frozen.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the time, the remainder and all capture registers are zero, the control register reads 0, and the increment register reads the INC_RESET parameter (default 0x0140_0000, 20 ns).
- R2: Register addresses are as follows. 0 is control. 1 is the increment (writes go to staging, reads return the active value). 2, 3 and 4 hold the new time: nanoseconds, seconds bits 31:0 and seconds bits 47:32. 5, 6 and 7 are the read-only captured nanoseconds, seconds low word and seconds high word. Control fields are command at [1:0], load-time at bit 2, load-increment at bit 3 and source at [5:4].
- R3: Each running clock, the step is the increment shifted right by 20 plus the carry out of the 20-bit remainder, and the remainder then holds the low 20 bits of its sum with the fractional part of the increment.
- R4: A sum of 1,000,000,000 ns or more is reduced by 1,000,000,000 and the seconds go up by one. The seconds wrap from 2^48-1 to 0, and the nanoseconds always stay below 1,000,000,000.
- R5: The time advances only while the source field is 01. Any other source code holds the time unchanged.
- R6: A command write with code 1 (capture) or 2 (reset) is accepted only while the field reads 0. It reads back the accepted code after the accepting edge and after the edge that follows, and reads 0 after the edge after that.
- R7: A capture copies the time, as it stands just before the first edge after acceptance, into the three capture registers in one cycle. The capture registers change at no other time.
- R8: A reset command sets the nanoseconds, the seconds and the remainder to zero.
- R9: Writing 1 to the load-time bit loads the staged time on the next edge and clears the remainder. A staged nanoseconds value of 1,000,000,000 or more is loaded as 999,999,999. The bit reads 1 for two edges and then clears. A request made while it reads 1 is refused. If a load and a reset act on the same edge, the load wins.
- R10: Writing 1 to the load-increment bit moves the staged increment into the active increment on the next edge. The bit reads 1 for two edges and then clears. The active increment changes at no other time.
- R11: A command written while the field is non-zero, and the reserved code 3, are ignored and leave the time and the command field unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Write qualifier for reg_valid |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |

## Verification
Some faults leave the time itself wrong: a bad remainder carry, a missed nanosecond rollover or a lost seconds carry. These show up in the next capture as a time that is off by a nanosecond or by a whole second, so the bench counts a known number of running edges and compares the capture exactly. Faults in the staging and handshake logic show at the control readback within two edges of the request, as a bit that clears early, clears late or never clears. A refused request that is wrongly accepted, or an ignored command that is wrongly acted on, leaves a captured time that differs from the loaded one.

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int FRAC_W = 20,
  parameter int INC_W = 32,
  parameter int NS_W = 32,
  parameter int SEC_W = 48,
  parameter int SEC_LO_W = 32,
  parameter logic [NS_W-1:0] NS_PER_SEC = 32'd1_000_000_000,
  parameter logic [INC_W-1:0] INC_RESET = 32'h0140_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_valid,
  input  logic        reg_write,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int SEC_HI_W = SEC_W - SEC_LO_W;
  localparam int INT_W = INC_W - FRAC_W;
  localparam logic [1:0] CMD_IDLE = 2'd0;
  localparam logic [1:0] CMD_CAP  = 2'd1;
  localparam logic [1:0] CMD_RST  = 2'd2;
  localparam logic [1:0] SRC_ADJ  = 2'd1;

  logic [1:0]          cmd_q, src_q;
  logic                cmd_done, lt_pend, lt_done, li_pend, li_done;
  logic [INC_W-1:0]    inc_act, inc_stage;
  logic [NS_W-1:0]     ofs_ns, ns_q, cap_ns;
  logic [SEC_LO_W-1:0] ofs_slo;
  logic [SEC_HI_W-1:0] ofs_shi;
  logic [SEC_W-1:0]    sec_q, cap_sec;
  logic [FRAC_W-1:0]   frac_q;

  wire wr      = reg_valid && reg_write;
  wire ctrl_wr = wr && (reg_addr == 3'd0);
  wire req_ok  = (reg_wdata[1:0] == CMD_CAP) || (reg_wdata[1:0] == CMD_RST);
  wire do_cap  = (cmd_q == CMD_CAP) && !cmd_done;
  wire do_rst  = (cmd_q == CMD_RST) && !cmd_done;
  wire do_lt   = lt_pend && !lt_done;
  wire do_li   = li_pend && !li_done;
  wire run     = (src_q == SRC_ADJ);

  wire [FRAC_W:0] frac_sum = {1'b0, frac_q} + {1'b0, inc_act[FRAC_W-1:0]};
  wire [NS_W:0]   ns_sum   = {1'b0, ns_q} + (NS_W+1)'(inc_act[INC_W-1:FRAC_W])
                             + (NS_W+1)'(frac_sum[FRAC_W]);
  wire            roll     = ns_sum >= {1'b0, NS_PER_SEC};
  wire [NS_W:0]   ns_red   = ns_sum - {1'b0, NS_PER_SEC};
  wire [NS_W-1:0] ns_next  = roll ? ns_red[NS_W-1:0] : ns_sum[NS_W-1:0];
  wire [SEC_W-1:0] sec_next = sec_q + SEC_W'(roll);
  wire [NS_W-1:0] ofs_ns_sat = (ofs_ns >= NS_PER_SEC) ? NS_PER_SEC - 1'b1 : ofs_ns;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= CMD_IDLE;
      cmd_done <= 1'b0;
      lt_pend  <= 1'b0;
      lt_done  <= 1'b0;
      li_pend  <= 1'b0;
      li_done  <= 1'b0;
      src_q    <= 2'd0;
    end else begin
      if (ctrl_wr) src_q <= reg_wdata[5:4];
      if (cmd_q != CMD_IDLE) begin
        if (cmd_done) begin
          cmd_q    <= CMD_IDLE;
          cmd_done <= 1'b0;
        end else cmd_done <= 1'b1;
      end else if (ctrl_wr && req_ok) cmd_q <= reg_wdata[1:0];
      if (lt_pend) begin
        if (lt_done) begin
          lt_pend <= 1'b0;
          lt_done <= 1'b0;
        end else lt_done <= 1'b1;
      end else if (ctrl_wr && reg_wdata[2]) lt_pend <= 1'b1;
      if (li_pend) begin
        if (li_done) begin
          li_pend <= 1'b0;
          li_done <= 1'b0;
        end else li_done <= 1'b1;
      end else if (ctrl_wr && reg_wdata[3]) li_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inc_stage <= INC_RESET;
      ofs_ns    <= '0;
      ofs_slo   <= '0;
      ofs_shi   <= '0;
    end else if (wr) begin
      case (reg_addr)
        3'd1: inc_stage <= reg_wdata[INC_W-1:0];
        3'd2: ofs_ns    <= reg_wdata[NS_W-1:0];
        3'd3: ofs_slo   <= reg_wdata[SEC_LO_W-1:0];
        3'd4: ofs_shi   <= reg_wdata[SEC_HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) inc_act <= INC_RESET;
    else if (do_li) inc_act <= inc_stage;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ns_q   <= '0;
      sec_q  <= '0;
      frac_q <= '0;
    end else if (do_lt) begin
      ns_q   <= ofs_ns_sat;
      sec_q  <= {ofs_shi, ofs_slo};
      frac_q <= '0;
    end else if (do_rst) begin
      ns_q   <= '0;
      sec_q  <= '0;
      frac_q <= '0;
    end else if (run) begin
      ns_q   <= ns_next;
      sec_q  <= sec_next;
      frac_q <= frac_sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_ns  <= '0;
      cap_sec <= '0;
    end else if (do_cap) begin
      cap_ns  <= ns_q;
      cap_sec <= sec_q;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {26'd0, src_q, li_pend, lt_pend, cmd_q};
      3'd1:    reg_rdata = 32'(inc_act);
      3'd2:    reg_rdata = 32'(ofs_ns);
      3'd3:    reg_rdata = 32'(ofs_slo);
      3'd4:    reg_rdata = 32'(ofs_shi);
      3'd5:    reg_rdata = 32'(cap_ns);
      3'd6:    reg_rdata = 32'(cap_sec[SEC_LO_W-1:0]);
      default: reg_rdata = 32'(cap_sec[SEC_W-1:SEC_LO_W]);
    endcase
  end

  AST_NS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ns_q < NS_PER_SEC); // R4
  AST_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !do_lt && !do_rst) |=> ($stable(ns_q) && $stable(sec_q))); // R5
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_IDLE && !cmd_done) |=> ($stable(cmd_q) && cmd_done)); // R6
  AST_CMD_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_IDLE && cmd_done) |=> (cmd_q == CMD_IDLE)); // R6
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) cmd_q != 2'd3); // R11
  AST_CAP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !do_cap |=> ($stable(cap_ns) && $stable(cap_sec))); // R7
  AST_LT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_pend && !lt_done) |=> lt_pend); // R9
  AST_LT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_pend && lt_done) |=> !lt_pend); // R9
  AST_INC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !do_li |=> $stable(inc_act)); // R10
  AST_LI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (li_pend && li_done) |=> !li_pend); // R10
endmodule

// File: tb/sim_ptp_time_counter.sv
module sim_ptp_time_counter;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NSEC = 32'd1_000_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  ptp_time_counter u0 (.clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
                       .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_time(input logic [31:0] ns, input logic [47:0] sec);
    wr(3'd2, ns); wr(3'd3, sec[31:0]); wr(3'd4, 32'(sec[47:32]));
    wr(3'd0, 32'h4); idle(2);
  endtask

  task automatic set_inc(input logic [31:0] inc);
    wr(3'd1, inc); wr(3'd0, 32'h8); idle(2);
  endtask

  task automatic cap_time(output logic [31:0] ns, output logic [47:0] sec);
    logic [31:0] lo, hi;
    idle(2);
    wr(3'd0, 32'h1); idle(2);
    rd(3'd5, ns); rd(3'd6, lo); rd(3'd7, hi);
    sec = {hi[15:0], lo};
  endtask

  task automatic run(input int k);
    wr(3'd0, 32'h10); idle(k-1); wr(3'd0, 32'h0);
  endtask

  task automatic model(inout logic [31:0] ns, inout logic [47:0] sec, input logic [31:0] inc, input int n);
    logic [20:0] f = '0;
    for (int i = 0; i < n; i++) begin
      logic [32:0] s;
      f = {1'b0, f[19:0]} + {1'b0, inc[19:0]};
      s = {1'b0, ns} + 33'(inc[31:20]) + 33'(f[20]);
      if (s >= {1'b0, NSEC}) begin s = s - {1'b0, NSEC}; sec = sec + 48'd1; end
      ns = s[31:0];
    end
  endtask

  task automatic check_time(input string tag, input logic [31:0] ens, input logic [47:0] esec);
    logic [31:0] ns; logic [47:0] sec;
    cap_time(ns, sec);
    check({tag, " ns"}, 64'(ns), 64'(ens));
    check({tag, " sec"}, 64'(sec), 64'(esec));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); check("R1 ctrl", 64'(d), 64'd0);
    rd(3'd1, d); check("R1 inc", 64'(d), 64'h0140_0000);
    rd(3'd5, d); check("R1 cap ns", 64'(d), 64'd0);
    rd(3'd7, d); check("R1 cap sec hi", 64'(d), 64'd0);
    check_time("R1 time", 32'd0, 48'd0);
  endtask

  task automatic t_load;
    set_time(32'd123_456_789, 48'h1234_89AB_CDEF);
    check_time("R9 R2 load", 32'd123_456_789, 48'h1234_89AB_CDEF);
    set_time(32'hFFFF_FFFF, 48'd7);
    check_time("R9 saturate", 32'd999_999_999, 48'd7);
  endtask

  task automatic t_handshake;
    logic [31:0] d;
    idle(2);
    wr(3'd0, 32'h1);
    rd(3'd0, d); check("R6 cmd edge1", 64'(d[1:0]), 64'd1);
    idle(1); rd(3'd0, d); check("R6 cmd edge2", 64'(d[1:0]), 64'd1);
    idle(1); rd(3'd0, d); check("R6 cmd clear", 64'(d[1:0]), 64'd0);
    wr(3'd0, 32'h4);
    rd(3'd0, d); check("R9 lt edge1", 64'(d[2]), 64'd1);
    idle(1); rd(3'd0, d); check("R9 lt edge2", 64'(d[2]), 64'd1);
    idle(1); rd(3'd0, d); check("R9 lt clear", 64'(d[2]), 64'd0);
  endtask

  task automatic t_ignore;
    logic [31:0] d;
    set_time(32'd4242, 48'd99);
    wr(3'd0, 32'h1); wr(3'd0, 32'h2); idle(2);
    check_time("R11 busy reset ignored", 32'd4242, 48'd99);
    wr(3'd0, 32'h3);
    rd(3'd0, d); check("R11 reserved code", 64'(d[1:0]), 64'd0);
    wr(3'd2, 32'd777); wr(3'd3, 32'd1); wr(3'd4, 32'd0);
    wr(3'd0, 32'h4); wr(3'd0, 32'h4); wr(3'd2, 32'd888); idle(3);
    check_time("R9 busy load refused", 32'd777, 48'd1);
  endtask

  task automatic t_reset_cmd;
    set_inc(32'h0018_0000);
    set_time(32'd5000, 48'd3);
    run(1);
    idle(2); wr(3'd0, 32'h2); idle(2);
    check_time("R8 reset zero", 32'd0, 48'd0);
    run(1);
    check_time("R8 remainder cleared", 32'd1, 48'd0);
    set_time(32'd10, 48'd0); run(1);
    set_time(32'd10, 48'd0); run(1);
    check_time("R9 load clears remainder", 32'd11, 48'd0);
  endtask

  task automatic t_count;
    logic [31:0] d, ns; logic [47:0] sec;
    wr(3'd1, 32'h0028_0000);
    rd(3'd1, d); check("R10 staged not active", 64'(d), 64'h0018_0000);
    wr(3'd0, 32'h8);
    rd(3'd0, d); check("R10 li pending", 64'(d[3]), 64'd1);
    idle(2);
    rd(3'd1, d); check("R10 applied", 64'(d), 64'h0028_0000);
    rd(3'd0, d); check("R10 li clear", 64'(d[3]), 64'd0);
    set_inc(32'h0018_0000);
    set_time(32'd1000, 48'd0); run(4);
    check_time("R3 frac 1.5ns x4", 32'd1006, 48'd0);
    set_inc(32'h0014_CCCD);
    ns = 32'd2000; sec = 48'd5; model(ns, sec, 32'h0014_CCCD, 9);
    set_time(32'd2000, 48'd5); run(9);
    check_time("R3 frac 1.3ns x9", ns, sec);
  endtask

  task automatic t_roll;
    set_inc(32'h0040_0000);
    set_time(32'd999_999_998, 48'hFFFF_FFFF_FFFF); run(1);
    check_time("R4 sec wrap", 32'd2, 48'd0);
    set_time(32'd999_999_999, 48'h0000_FFFF_FFFF); run(1);
    check_time("R4 sec low carry", 32'd3, 48'h0001_0000_0000);
    set_time(32'd999_999_996, 48'd8); run(1);
    check_time("R4 exact second", 32'd0, 48'd9);
  endtask

  task automatic t_halt;
    set_time(32'd321, 48'd4);
    wr(3'd0, 32'h20); idle(5); wr(3'd0, 32'h30); idle(3); wr(3'd0, 32'h0);
    check_time("R5 halted", 32'd321, 48'd4);
  endtask

  task automatic t_snapshot;
    logic [31:0] d, lo;
    set_inc(32'h0140_0000);
    set_time(32'd500, 48'd5);
    wr(3'd0, 32'h10); idle(2); wr(3'd0, 32'h11); wr(3'd0, 32'h0);
    rd(3'd5, d); check("R7 running snapshot ns", 64'(d), 64'd560);
    rd(3'd6, lo); check("R7 running snapshot sec", 64'(lo), 64'd5);
    check_time("R7 after halt", 32'd580, 48'd5);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_load();
    t_handshake();
    t_ignore();
    t_reset_cmd();
    t_count();
    t_roll();
    t_halt();
    t_snapshot();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule